// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block picks where each ALU operand of the instruction now in execute comes from. The pipeline is a five-stage in-order integer pipeline: fetch, decode with register read, execute, memory, writeback. A result exists at the end of execute, but it is not written back to the register file until two stages later. A dependent instruction that follows close behind would otherwise read a stale value. The selector compares both source register numbers of the executing instruction with the destination number and write flag held in the two pipeline registers ahead of it. It then produces a 2-bit select code for each operand.

The register file writes in the first half of a cycle and reads in the second half. For this reason only the two nearest older instructions ever act as bypass sources. An instruction three slots behind its producer reads the fresh value straight from the register file.

The top level is a thin wrapper. It holds the two pipeline registers (execute/memory and memory/writeback) and one operand multiplexer per source. The select codes and the chosen operand values are both visible at the ports. The executing instruction's result arrives as an input, because the ALU, register file, load-use stall and branch logic sit elsewhere.

Top module: `fwd_pipe_top`

## Requirements
- R1: After reset, both pipeline registers hold no pending write. The first instruction after reset therefore gets select 00 on both operands, even if a producer was in flight before reset.
- R2: If the execute/memory stage has its write flag set and a nonzero destination equal to a source register, that operand's select is 10. The operand then equals the result the previous instruction presented in execute.
- R3: If only the memory/writeback stage matches a source register (write flag set, nonzero destination), that operand's select is 01. The operand then equals the result from two instructions earlier.
- R4: If both stages match the same source register, the select is 10 and the newer (execute/memory) value is used.
- R5: Register zero is never a bypass source. A source of zero gets select 00 and the register-file value, even after a write to destination zero.
- R6: A stage whose write flag is clear is never a bypass source, even when its destination number matches.
- R7: The two operands are decided independently. One instruction can take operand A from one stage and operand B from the other.
- R8: A producer three instructions ahead needs no bypass. The select is 00 and the register-file value is used.
- R9: When four consecutive instructions all read one producer's destination, each of them sees the new value (via 10, then 01, then 00 twice).
- R10: The select code 11 is never produced; 00 means register file, 10 means execute/memory, 01 means memory/writeback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Active-low synchronous reset of the pipeline registers |
| ex_rs1 | input | RA_W | First source register number of the instruction in execute |
| ex_rs2 | input | RA_W | Second source register number of the instruction in execute |
| ex_rd | input | RA_W | Destination register number of the instruction in execute |
| ex_we | input | 1 | Instruction in execute writes its destination |
| ex_rf_a | input | DATA_W | Register-file read value for the first source |
| ex_rf_b | input | DATA_W | Register-file read value for the second source |
| ex_result | input | DATA_W | Result produced in execute this cycle |
| sel_a | output | 2 | Select code for operand A |
| sel_b | output | 2 | Select code for operand B |
| opnd_a | output | DATA_W | Operand A after the bypass multiplexer |
| opnd_b | output | DATA_W | Operand B after the bypass multiplexer |

## Verification
The assertions assume the pipeline advances one instruction every cycle. They also assume the register-file inputs already reflect every write retired three or more slots earlier, since the block cannot check either condition itself.

The stimulus keeps to these assumptions. It issues exactly one instruction per clock and never models a stall. Wherever a consumer sits three or more slots behind its producer, it supplies the register-file value that the producer would by then have written. Fillers between producers and consumers use source and destination zero with the write flag clear, so they never create an unintended match.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    // Operand source code; values are decoded by the operand multiplexer
    typedef enum logic [1:0] {
        SEL_RF    = 2'b00,
        SEL_MEMWB = 2'b01,
        SEL_EXMEM = 2'b10
    } fwd_sel_e;

endpackage

// File: rtl/fwd_select.sv
module fwd_select #(
    parameter int RA_W = 5
) (
    input  logic [RA_W-1:0]   src,
    input  logic [RA_W-1:0]   near_rd,
    input  logic              near_we,
    input  logic [RA_W-1:0]   far_rd,
    input  logic              far_we,
    output fwd_pkg::fwd_sel_e sel
);
    localparam logic [RA_W-1:0] ZERO_REG = '0;

    logic near_hit;
    logic far_hit;

    always_comb begin
        near_hit = near_we && (near_rd != ZERO_REG) && (near_rd == src);
        far_hit  = far_we  && (far_rd  != ZERO_REG) && (far_rd  == src);
        // the nearer stage holds the newer value and takes priority
        if (near_hit) begin
            sel = fwd_pkg::SEL_EXMEM;
        end else if (far_hit) begin
            sel = fwd_pkg::SEL_MEMWB;
        end else begin
            sel = fwd_pkg::SEL_RF;
        end
    end
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] near_val,
    input  logic [DATA_W-1:0] far_val,
    input  fwd_pkg::fwd_sel_e sel,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        unique case (sel)
            fwd_pkg::SEL_EXMEM: y = near_val;
            fwd_pkg::SEL_MEMWB: y = far_val;
            default:            y = rf_val;
        endcase
    end
endmodule

// File: rtl/fwd_pipe_top.sv
module fwd_pipe_top #(
    parameter int RA_W   = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RA_W-1:0]   ex_rs1,
    input  logic [RA_W-1:0]   ex_rs2,
    input  logic [RA_W-1:0]   ex_rd,
    input  logic              ex_we,
    input  logic [DATA_W-1:0] ex_rf_a,
    input  logic [DATA_W-1:0] ex_rf_b,
    input  logic [DATA_W-1:0] ex_result,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int NUM_SRC = 2;

    typedef struct packed {
        logic              we;
        logic [RA_W-1:0]   rd;
        logic [DATA_W-1:0] data;
    } stage_t;

    typedef struct packed {
        stage_t exmem;
        stage_t memwb;
    } pipe_t;

    pipe_t st_d;
    pipe_t st_q;

    always_comb begin
        st_d            = st_q;
        st_d.exmem.we   = ex_we;
        st_d.exmem.rd   = ex_rd;
        st_d.exmem.data = ex_result;
        st_d.memwb      = st_q.exmem;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [RA_W-1:0]   src_num [NUM_SRC];
    logic [DATA_W-1:0] rf_val  [NUM_SRC];
    logic [DATA_W-1:0] opnd    [NUM_SRC];
    fwd_pkg::fwd_sel_e sel     [NUM_SRC];

    always_comb begin
        src_num[0] = ex_rs1;
        src_num[1] = ex_rs2;
        rf_val[0]  = ex_rf_a;
        rf_val[1]  = ex_rf_b;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        fwd_select #(.RA_W(RA_W)) u_sel (
            .src     (src_num[g]),
            .near_rd (st_q.exmem.rd),
            .near_we (st_q.exmem.we),
            .far_rd  (st_q.memwb.rd),
            .far_we  (st_q.memwb.we),
            .sel     (sel[g])
        );
        fwd_opmux #(.DATA_W(DATA_W)) u_mux (
            .rf_val   (rf_val[g]),
            .near_val (st_q.exmem.data),
            .far_val  (st_q.memwb.data),
            .sel      (sel[g]),
            .y        (opnd[g])
        );
    end

    always_comb begin
        sel_a  = sel[0];
        sel_b  = sel[1];
        opnd_a = opnd[0];
        opnd_b = opnd[1];
    end

    // R2
    exmem_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a == 2'b10) |-> (opnd_a == $past(ex_result)));

    // R3
    memwb_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b == 2'b01) |-> (opnd_b == st_q.memwb.data));

    // R4
    newer_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs1 != '0 && st_q.exmem.we && st_q.exmem.rd == ex_rs1
         && st_q.memwb.we && st_q.memwb.rd == ex_rs1) |-> (sel_a == 2'b10));

    // R5
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs1 == '0) |-> (sel_a == 2'b00 && opnd_a == ex_rf_a));

    // R6
    no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.exmem.we && !st_q.memwb.we) |-> (sel_a == 2'b00 && sel_b == 2'b00));

    // R10
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a != 2'b11) && (sel_b != 2'b11));
endmodule

// File: tb/sim_fwd_pipe_top.sv
module sim_fwd_pipe_top;
    localparam int CLK_PERIOD = 10;
    localparam int RA_W = 5;
    localparam int DW   = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [RA_W-1:0] ex_rs1 = '0, ex_rs2 = '0, ex_rd = '0;
    logic          ex_we = 1'b0;
    logic [DW-1:0] ex_rf_a = '0, ex_rf_b = '0, ex_result = '0;
    logic [1:0]    sel_a, sel_b;
    logic [DW-1:0] opnd_a, opnd_b;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fwd_pipe_top #(.RA_W(RA_W), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .ex_rd(ex_rd), .ex_we(ex_we), .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
        .ex_result(ex_result), .sel_a(sel_a), .sel_b(sel_b),
        .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one instruction in execute for one cycle, outputs checked mid-cycle
    task automatic issue(input logic [RA_W-1:0] rs1, input logic [RA_W-1:0] rs2,
                         input logic [RA_W-1:0] rd, input logic we,
                         input logic [DW-1:0] rfa, input logic [DW-1:0] rfb,
                         input logic [DW-1:0] res,
                         input logic [1:0] xsa, input logic [1:0] xsb,
                         input logic [DW-1:0] xa, input logic [DW-1:0] xb,
                         input string tag);
        ex_rs1 = rs1; ex_rs2 = rs2; ex_rd = rd; ex_we = we;
        ex_rf_a = rfa; ex_rf_b = rfb; ex_result = res;
        #(CLK_PERIOD/4);
        chk(sel_a == xsa, {tag, " sel_a"}, DW'(sel_a), DW'(xsa));
        chk(sel_b == xsb, {tag, " sel_b"}, DW'(sel_b), DW'(xsb));
        chk(opnd_a == xa, {tag, " opnd_a"}, opnd_a, xa);
        chk(opnd_b == xb, {tag, " opnd_b"}, opnd_b, xb);
        chk(sel_a != 2'b11 && sel_b != 2'b11, "R10 legal code",
            DW'({sel_a, sel_b}), 32'h0);
        @(posedge clk);
        #1;
    endtask

    task automatic filler();
        issue(0, 0, 0, 1'b0, 0, 0, 0, 2'b00, 2'b00, 0, 0, "filler");
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        issue(0, 0, 3, 1'b1, 0, 0, 32'h3333, 2'b00, 2'b00, 0, 0, "R1 pre");
        do_reset();
        issue(3, 3, 0, 1'b0, 32'h11, 32'h22, 0, 2'b00, 2'b00, 32'h11, 32'h22, "R1 after reset");
    endtask

    task automatic t_exmem();
        issue(0, 0, 5, 1'b1, 0, 0, 32'hA5A5_0001, 2'b00, 2'b00, 0, 0, "R2 prod");
        issue(5, 6, 0, 1'b0, 32'h1, 32'h66, 0, 2'b10, 2'b00, 32'hA5A5_0001, 32'h66, "R2 consumer");
    endtask

    task automatic t_memwb();
        issue(0, 0, 7, 1'b1, 0, 0, 32'h7777, 2'b00, 2'b00, 0, 0, "R3 prod");
        filler();
        issue(1, 7, 0, 1'b0, 32'h10, 32'h2, 0, 2'b00, 2'b01, 32'h10, 32'h7777, "R3 consumer");
    endtask

    task automatic t_both();
        issue(0, 0, 9, 1'b1, 0, 0, 32'h90, 2'b00, 2'b00, 0, 0, "R4 old");
        issue(0, 0, 9, 1'b1, 0, 0, 32'h91, 2'b00, 2'b00, 0, 0, "R4 new");
        issue(9, 9, 0, 1'b0, 32'h5, 32'h5, 0, 2'b10, 2'b10, 32'h91, 32'h91, "R4 consumer");
    endtask

    task automatic t_zero();
        issue(0, 0, 0, 1'b1, 0, 0, 32'hDEAD, 2'b00, 2'b00, 0, 0, "R5 prod far");
        issue(0, 0, 0, 1'b1, 0, 0, 32'hBEEF, 2'b00, 2'b00, 0, 0, "R5 prod near");
        issue(0, 0, 0, 1'b0, 0, 0, 0, 2'b00, 2'b00, 0, 0, "R5 consumer");
    endtask

    task automatic t_nowe();
        issue(0, 0, 8, 1'b0, 0, 0, 32'h8888, 2'b00, 2'b00, 0, 0, "R6 far");
        issue(0, 0, 8, 1'b0, 0, 0, 32'h8889, 2'b00, 2'b00, 0, 0, "R6 near");
        issue(8, 8, 0, 1'b0, 32'h44, 32'h45, 0, 2'b00, 2'b00, 32'h44, 32'h45, "R6 consumer");
    endtask

    task automatic t_indep();
        issue(0, 0, 10, 1'b1, 0, 0, 32'h1010, 2'b00, 2'b00, 0, 0, "R7 prod a");
        issue(0, 0, 11, 1'b1, 0, 0, 32'h1111, 2'b00, 2'b00, 0, 0, "R7 prod b");
        issue(10, 11, 0, 1'b0, 32'h1, 32'h2, 0, 2'b01, 2'b10, 32'h1010, 32'h1111, "R7 consumer");
    endtask

    task automatic t_third();
        issue(0, 0, 12, 1'b1, 0, 0, 32'h1212, 2'b00, 2'b00, 0, 0, "R8 prod");
        filler();
        filler();
        issue(12, 0, 0, 1'b0, 32'h1212, 0, 0, 2'b00, 2'b00, 32'h1212, 0, "R8 consumer");
    endtask

    task automatic t_chain();
        issue(0, 0, 13, 1'b1, 0, 0, 32'hC0DE, 2'b00, 2'b00, 0, 0, "R9 prod");
        issue(13, 0, 20, 1'b1, 32'h0, 0, 32'h20, 2'b10, 2'b00, 32'hC0DE, 0, "R9 first");
        issue(0, 13, 21, 1'b1, 0, 32'h0, 32'h21, 2'b00, 2'b01, 0, 32'hC0DE, "R9 second");
        issue(13, 0, 22, 1'b1, 32'hC0DE, 0, 32'h22, 2'b00, 2'b00, 32'hC0DE, 0, "R9 third");
        issue(0, 13, 23, 1'b1, 0, 32'hC0DE, 32'h23, 2'b00, 2'b00, 0, 32'hC0DE, "R9 fourth");
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset();
        t_exmem();
        t_memwb();
        t_both();
        t_zero();
        t_nowe();
        t_indep();
        t_third();
        t_chain();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule